// File: doc/BRIEF.md
# Timestamped Sample Stream Packetizer

This block accepts one stream of 64-bit payload lines, together with a per-line end-of-burst marker, and turns it into framed data packets on a 64-bit output stream. Each packet starts with one header line. An optional 64-bit time line may follow the header. The buffered payload lines come last. The packet size is given as a sample count, and each sample is a configured number of bytes wide, so the number of payload lines is derived from those two values. A burst may end on a partial packet. That short packet is emitted with its true length and carries the end-of-burst flag.

Each packet carries a wrapping 12-bit sequence number. Timed packets carry a time value. The first packet of a burst takes the configured start time. Each later packet of the same burst advances by the number of ticks that one packet spans. The stream identifiers, timing and sizing all come from static configuration inputs, which should be changed only while the block is idle. A synchronous clear discards a partly collected packet and restarts the sequence count.

Top module: `pkt_framer`

## Requirements
- R1: After reset or clear, `outValid` is low. `inReady` is high when the configuration is legal. The first packet afterwards carries sequence number 0.
- R2: A packet holds `cfgSpp*cfgBps/8` payload lines, unless the burst ends earlier. The block accepts input lines until that many are collected or a line with `inLast` high arrives.
- R3: The header line is laid out as follows: [63:62] type, which is 00 for data; [61] timed flag; [60] end-of-burst; [59:48] sequence; [47:32] byte length; [31:16] `cfgSrcId`; [15:0] `cfgDstId`. The byte length equals 8 × (payload lines + timed flag + 1).
- R4: The sequence number grows by one after every emitted packet and wraps from 4095 to 0.
- R5: A change of `cfgDstId` resets the sequence number, so the next packet carries 0.
- R6: When `cfgTimed` is 1, one time line follows the header. The first packet of a burst carries `cfgStartTime`. Each later packet of that burst carries the previous value plus `cfgTicks*cfgSpp`.
- R7: End-of-burst is set only in the packet that holds the line marked by `inLast`. That packet may be shorter than a full packet.
- R8: While `cfgSpp` is 0, `inReady` and `outValid` both stay low.
- R9: `outLast` is high only on the final payload line of a packet. While `outValid` is high and `outReady` is low, `outData` and `outLast` hold their values. No input is accepted while a packet is being emitted.
- R10: `clear` discards a partly collected packet, and that data never appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous clear of packet state and sequence |
| cfgSpp | input | 16 | Samples per packet |
| cfgBps | input | 4 | Bytes per sample |
| cfgTicks | input | 16 | Time ticks per sample |
| cfgTimed | input | 1 | Emit a time line after each header |
| cfgSrcId | input | 16 | Source stream identifier |
| cfgDstId | input | 16 | Destination stream identifier |
| cfgStartTime | input | 64 | Time of the first packet of a burst |
| inData | input | 64 | Input payload line |
| inValid | input | 1 | Input line valid |
| inLast | input | 1 | Input line ends the burst |
| inReady | output | 1 | Block accepts an input line |
| outData | output | 64 | Output packet line |
| outValid | output | 1 | Output line valid |
| outLast | output | 1 | Output line ends a packet |
| outReady | input | 1 | Downstream accepts the line |

## Verification
The first pattern is a timed burst of six lines at two lines per packet, run under periodic output stalls. It separates end-of-burst placement, time advance and the effect of back-pressure. A second burst shows that the time restarts at the configured start. An untimed five-line burst at four lines per packet produces a short final packet, which tests the length arithmetic. A 4097-packet burst of single-line packets exposes the 12-bit wrap. Further runs cover a destination change, a zero sample count held with input pending, and a clear that lands between two lines of one packet. Together they show that abandoned data and stale sequence numbers never leak out.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  typedef enum logic [1:0] {ST_FILL, ST_HDR, ST_TIME, ST_PAY} framerState_t;

  typedef struct packed {
    logic bufWrite;
    logic startPkt;
    logic pktDone;
    logic clearAll;
  } framerStrobe_t;
endpackage

// File: rtl/pkt_framer_ctrl.sv
module pkt_framer_ctrl
  import pkt_framer_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             cfgOk,
  input  logic [CNT_W-1:0] linesPerPkt,
  input  logic             cfgTimed,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             outLast,
  output framerState_t     state,
  output logic [CNT_W-1:0] wrCnt,
  output logic [CNT_W-1:0] rdIdx,
  output logic [CNT_W-1:0] pktLines,
  output logic             pktTimed,
  output framerStrobe_t    strobe
);
  logic accept, fire, closing;
  logic [CNT_W-1:0] cntNext;

  assign cntNext  = CNT_W'(wrCnt + 1'b1);
  assign inReady  = (state == ST_FILL) && cfgOk;
  assign accept   = inReady && inValid;
  assign closing  = accept && ((cntNext == linesPerPkt) || inLast);
  assign outValid = (state != ST_FILL) && cfgOk;
  assign fire     = outValid && outReady;
  assign outLast  = (state == ST_PAY) && (rdIdx == CNT_W'(pktLines - 1'b1));

  always_comb begin
    strobe.bufWrite = accept;
    strobe.startPkt = closing;
    strobe.pktDone  = fire && outLast;
    strobe.clearAll = clear;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state    <= ST_FILL;
      wrCnt    <= '0;
      rdIdx    <= '0;
      pktLines <= '0;
      pktTimed <= 1'b0;
    end else begin
      unique case (state)
        ST_FILL: if (accept) begin
          wrCnt <= cntNext;
          if (closing) begin
            state    <= ST_HDR;
            pktLines <= cntNext;
            pktTimed <= cfgTimed;
            wrCnt    <= '0;
          end
        end
        ST_HDR: if (fire) begin
          state <= pktTimed ? ST_TIME : ST_PAY;
          rdIdx <= '0;
        end
        ST_TIME: if (fire) state <= ST_PAY;
        ST_PAY: if (fire) begin
          if (outLast) state <= ST_FILL;
          else rdIdx <= CNT_W'(rdIdx + 1'b1);
        end
        default: state <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/pkt_framer_dp.sv
module pkt_framer_dp
  import pkt_framer_pkg::*;
#(
  parameter int MAX_LINES = 16,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  framerStrobe_t    strobe,
  input  framerState_t     state,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [CNT_W-1:0] pktLines,
  input  logic             pktTimed,
  input  logic [63:0]      inData,
  input  logic             inLast,
  input  logic [15:0]      cfgSpp,
  input  logic [15:0]      cfgTicks,
  input  logic [15:0]      cfgSrcId,
  input  logic [15:0]      cfgDstId,
  input  logic [63:0]      cfgStartTime,
  output logic [63:0]      outData
);
  logic [63:0] lineBuf [MAX_LINES];
  logic [11:0] seqNum;
  logic [63:0] pktTime, nextTime;
  logic        burstStart, eobLat;
  logic [15:0] dstSeen;
  logic [15:0] lenField;
  logic [31:0] stepTicks;
  logic [63:0] header;

  assign stepTicks = cfgTicks * cfgSpp;
  assign lenField  = {13'(16'(pktLines) + 16'(pktTimed) + 16'd1), 3'b000};
  assign header    = {2'b00, pktTimed, eobLat, seqNum, lenField, cfgSrcId, cfgDstId};

  always_ff @(posedge clk) begin
    if (strobe.bufWrite) lineBuf[wrIdx] <= inData;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clearAll) begin
      seqNum     <= '0;
      pktTime    <= '0;
      nextTime   <= '0;
      burstStart <= 1'b1;
      eobLat     <= 1'b0;
      dstSeen    <= cfgDstId;
    end else begin
      if (strobe.startPkt) begin
        eobLat  <= inLast;
        pktTime <= burstStart ? cfgStartTime : nextTime;
      end
      if (strobe.pktDone) begin
        seqNum     <= seqNum + 12'd1;
        nextTime   <= pktTime + 64'(stepTicks);
        burstStart <= eobLat;
      end
      if (cfgDstId != dstSeen) begin
        dstSeen <= cfgDstId;
        seqNum  <= '0;
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_HDR:  outData = header;
      ST_TIME: outData = pktTime;
      ST_PAY:  outData = lineBuf[rdIdx];
      default: outData = '0;
    endcase
  end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pkt_framer_pkg::*;
#(
  parameter int MAX_LINES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic [15:0] cfgSpp,
  input  logic [3:0]  cfgBps,
  input  logic [15:0] cfgTicks,
  input  logic        cfgTimed,
  input  logic [15:0] cfgSrcId,
  input  logic [15:0] cfgDstId,
  input  logic [63:0] cfgStartTime,
  input  logic [63:0] inData,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output logic [63:0] outData,
  output logic        outValid,
  output logic        outLast,
  input  logic        outReady
);
  localparam int IDX_W = $clog2(MAX_LINES);
  localparam int CNT_W = $clog2(MAX_LINES + 1);

  logic [19:0]      sizeBytes;
  logic [16:0]      linesWide;
  logic             cfgOk;
  logic [CNT_W-1:0] linesPerPkt, wrCnt, rdIdx, pktLines;
  logic             pktTimed;
  framerState_t     state;
  framerStrobe_t    strobe;

  assign sizeBytes   = {4'b0, cfgSpp} * {16'b0, cfgBps};
  assign linesWide   = sizeBytes[19:3];
  assign cfgOk       = (cfgSpp != 16'd0) && (linesWide != 17'd0) && (linesWide <= 17'(MAX_LINES));
  assign linesPerPkt = CNT_W'(linesWide);

  pkt_framer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .clear(clear), .cfgOk(cfgOk), .linesPerPkt(linesPerPkt),
    .cfgTimed(cfgTimed), .inValid(inValid), .inLast(inLast), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .outLast(outLast), .state(state),
    .wrCnt(wrCnt), .rdIdx(rdIdx), .pktLines(pktLines), .pktTimed(pktTimed),
    .strobe(strobe)
  );

  pkt_framer_dp #(.MAX_LINES(MAX_LINES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .state(state),
    .wrIdx(wrCnt[IDX_W-1:0]), .rdIdx(rdIdx[IDX_W-1:0]), .pktLines(pktLines),
    .pktTimed(pktTimed), .inData(inData), .inLast(inLast), .cfgSpp(cfgSpp),
    .cfgTicks(cfgTicks), .cfgSrcId(cfgSrcId), .cfgDstId(cfgDstId),
    .cfgStartTime(cfgStartTime), .outData(outData)
  );
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk (
  input logic        clk,
  input logic        rst,
  input logic        clear,
  input logic [15:0] cfgSpp,
  input logic [15:0] cfgDstId,
  input logic        inReady,
  input logic [63:0] outData,
  input logic        outValid,
  input logic        outLast,
  input logic        outReady
);
  logic        hdrNext, havePrev;
  logic [11:0] prevSeq;
  logic [15:0] dstReg;
  logic        hdrBeat;

  assign hdrBeat = outValid && hdrNext;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hdrNext  <= 1'b1;
      havePrev <= 1'b0;
      prevSeq  <= '0;
      dstReg   <= cfgDstId;
    end else begin
      if (outValid && outReady) hdrNext <= outLast;
      if (hdrBeat && outReady) begin
        prevSeq  <= outData[59:48];
        havePrev <= 1'b1;
      end
      if (cfgDstId != dstReg) begin
        dstReg   <= cfgDstId;
        havePrev <= 1'b0;
      end
    end
  end

  assert_zero_spp_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (cfgSpp == 16'd0) |-> (!outValid && !inReady));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady && !clear) |=>
      ((cfgSpp == 16'd0) || (outValid && $stable(outData) && $stable(outLast))));

  assert_no_input_while_emit_R9: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  assert_header_shape_R3: assert property (@(posedge clk) disable iff (rst || clear)
    hdrBeat |-> (outData[63:62] == 2'b00 && outData[34:32] == 3'b000 &&
                 outData[47:32] >= 16'd16 && !outLast));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (rst || clear)
    (hdrBeat && outReady && havePrev && (cfgDstId == dstReg)) |->
      (outData[59:48] == 12'(prevSeq + 12'd1)));
endmodule

bind pkt_framer pkt_framer_chk u_chk (
  .clk(clk), .rst(rst), .clear(clear), .cfgSpp(cfgSpp), .cfgDstId(cfgDstId),
  .inReady(inReady), .outData(outData), .outValid(outValid), .outLast(outLast),
  .outReady(outReady)
);

// File: tb/sim_pkt_framer.sv
`timescale 1ns/1ps
module sim_pkt_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear = 1'b0;
  logic [15:0] cfgSpp = 16'd4;
  logic [3:0]  cfgBps = 4'd4;
  logic [15:0] cfgTicks = 16'd3;
  logic        cfgTimed = 1'b1;
  logic [15:0] cfgSrcId = 16'h0A10;
  logic [15:0] cfgDstId = 16'h0B20;
  logic [63:0] cfgStartTime = 64'd1000;
  logic [63:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic [63:0] outData;
  logic        outValid;
  logic        outLast;
  logic        outReady = 1'b1;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit stallOn = 0;
  int stallCnt = 0;
  logic [64:0] beats [$];
  int qp = 0;

  always #2.5 clk = ~clk;

  pkt_framer u0 (
    .clk(clk), .rst(rst), .clear(clear), .cfgSpp(cfgSpp), .cfgBps(cfgBps),
    .cfgTicks(cfgTicks), .cfgTimed(cfgTimed), .cfgSrcId(cfgSrcId), .cfgDstId(cfgDstId),
    .cfgStartTime(cfgStartTime), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outData(outData), .outValid(outValid), .outLast(outLast),
    .outReady(outReady)
  );

  // output sink: drive ready at the falling edge, record beats taken at the next rise
  initial forever begin
    @(negedge clk);
    stallCnt++;
    outReady = !(stallOn && (stallCnt % 3 == 0));
    #1;
    if (outValid && outReady) beats.push_back({outLast, outData});
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushLine(input logic [63:0] d, input logic l);
    @(negedge clk);
    inData = d; inLast = l; inValid = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic sendBurst(input int n, input logic [63:0] base);
    for (int i = 0; i < n; i++) pushLine(base + 64'(i), i == n - 1);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic waitBeats(input int n);
    int guard = 0;
    while (beats.size() < n && guard < 40000) begin
      @(posedge clk);
      guard++;
    end
    repeat (10) @(posedge clk);
  endtask

  task automatic startTest();
    beats.delete();
    qp = 0;
  endtask

  task automatic chkPkt(input string tag, input bit eob, input logic [11:0] seq, input bit timed,
                        input int lines, input logic [63:0] tim, input logic [63:0] base);
    logic [63:0] expHdr;
    logic [64:0] b;
    expHdr = {2'b00, timed, eob, seq, 16'(8 * (lines + int'(timed) + 1)), cfgSrcId, cfgDstId};
    if (qp >= beats.size()) begin
      chk(0, {tag, " missing header"}, 64'(beats.size()), 64'(qp));
      return;
    end
    b = beats[qp++];
    chk(b[63:0] == expHdr && !b[64], {tag, " header (R3)"}, b[63:0], expHdr);
    if (timed) begin
      b = beats[qp++];
      chk(b[63:0] == tim && !b[64], {tag, " time line (R6)"}, b[63:0], tim);
    end
    for (int k = 0; k < lines; k++) begin
      b = beats[qp++];
      chk(b[63:0] == base + 64'(k) && b[64] == (k == lines - 1), {tag, " payload/last (R2 R9)"},
          b[64:1], {base[62:0] + 63'(k), 1'(k == lines - 1)});
    end
  endtask

  task automatic testReset();
    startTest();
    chk(outValid == 1'b0 && inReady == 1'b1, "R1 reset state", {62'b0, outValid, inReady}, 64'd1);
  endtask

  task automatic testTimedBursts();
    startTest();
    stallOn = 1; cfgSpp = 16'd4; cfgBps = 4'd4; cfgTimed = 1'b1;
    sendBurst(6, 64'h100);
    waitBeats(12);
    chk(beats.size() == 12, "R2 beat count timed burst", 64'(beats.size()), 64'd12);
    chkPkt("R1 first pkt", 0, 12'd0, 1, 2, 64'd1000, 64'h100);
    chkPkt("R6 second pkt", 0, 12'd1, 1, 2, 64'd1012, 64'h102);
    chkPkt("R7 final pkt eob", 1, 12'd2, 1, 2, 64'd1024, 64'h104);
    startTest();
    sendBurst(2, 64'h200);
    waitBeats(4);
    chkPkt("R6 time restart next burst", 1, 12'd3, 1, 2, 64'd1000, 64'h200);
    stallOn = 0;
  endtask

  task automatic testShortFinal();
    startTest();
    cfgSpp = 16'd8; cfgBps = 4'd4; cfgTimed = 1'b0;
    sendBurst(5, 64'h300);
    waitBeats(7);
    chk(beats.size() == 7, "R7 beat count short burst", 64'(beats.size()), 64'd7);
    chkPkt("R2 full 4-line pkt", 0, 12'd4, 0, 4, 64'd0, 64'h300);
    chkPkt("R7 short final pkt", 1, 12'd5, 0, 1, 64'd0, 64'h304);
  endtask

  task automatic testDstChange();
    startTest();
    cfgSpp = 16'd4; cfgBps = 4'd4; cfgTimed = 1'b0;
    @(negedge clk); cfgDstId = 16'h0C30;
    repeat (3) @(posedge clk);
    sendBurst(2, 64'h400);
    waitBeats(3);
    chkPkt("R5 seq reset on dst change", 1, 12'd0, 0, 2, 64'd0, 64'h400);
  endtask

  task automatic testWrap();
    logic [64:0] h;
    startTest();
    cfgSpp = 16'd2; cfgBps = 4'd4; cfgTimed = 1'b0;
    @(negedge clk); cfgDstId = 16'h0D40;
    repeat (3) @(posedge clk);
    sendBurst(4097, 64'h10000);
    waitBeats(8194);
    chk(beats.size() == 8194, "R4 beat count wrap burst", 64'(beats.size()), 64'd8194);
    if (beats.size() == 8194) begin
      h = beats[2 * 4095];
      chk(h[59:48] == 12'd4095 && !h[60], "R4 seq 4095 no eob", 64'(h[60:48]), 64'd4095);
      h = beats[2 * 4096];
      chk(h[59:48] == 12'd0 && h[60], "R4 seq wraps to 0 with eob (R7)", 64'(h[60:48]), 64'h1000);
      h = beats[2 * 4096 + 1];
      chk(h[63:0] == 64'h10000 + 64'd4096 && h[64], "R2 one-line pkt payload", h[63:0], 64'h11000);
    end
  endtask

  task automatic testZeroSpp();
    bit sawBad = 0;
    startTest();
    @(negedge clk);
    cfgSpp = 16'd0;
    inData = 64'h500; inLast = 1'b1; inValid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      #1;
      if (inReady || outValid) sawBad = 1;
      @(negedge clk);
    end
    inValid = 1'b0;
    chk(!sawBad && beats.size() == 0, "R8 zero spp refuses", 64'(beats.size()), 64'd0);
    cfgSpp = 16'd2;
    sendBurst(1, 64'h600);
    waitBeats(2);
    chk(beats.size() == 2 && beats[1][63:0] == 64'h600, "R8 resumes after legal spp",
        64'(beats.size()), 64'd2);
  endtask

  task automatic testClear();
    startTest();
    cfgSpp = 16'd4; cfgBps = 4'd4; cfgTimed = 1'b0;
    pushLine(64'hA0, 1'b0);
    @(negedge clk);
    inValid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(outValid == 1'b0, "R1 idle after clear", 64'(outValid), 64'd0);
    sendBurst(2, 64'hB0);
    waitBeats(3);
    chk(beats.size() == 3, "R10 only new packet emitted", 64'(beats.size()), 64'd3);
    chkPkt("R10 discarded partial, seq restart", 1, 12'd0, 0, 2, 64'd0, 64'hB0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testTimedBursts();
    testShortFinal();
    testDstChange();
    testWrap();
    testZeroSpp();
    testClear();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule